// File: doc/BRIEF.md
# Signed Pulse-Width Row Update Driver

During a training step of a resistive crossbar, every row must be written with an amount set by its own signed error value. This block takes one signed error word per row and a shared time-scale constant, and turns them into per-row write control. Each row gets a two-bit select code and a write pulse. The code picks the true or the complemented column drive, depending on the error sign. The pulse lasts the error magnitude times the scale, in clock cycles. All rows are written at the same time, each with its own pulse length.

A one-cycle start strobe captures the error words and the scale. A fixed read interval of `READ_CYC` cycles follows. Then all row pulses begin together. Each row releases its select when its own count runs out. A one-cycle done pulse marks the moment the longest pulse ends. While an update is in progress, the block ignores further start strobes. The analog array, its converters and the column drivers are outside this block.

Top module: `rowpw_update_driver`

## Requirements
- R1: Each row r drives a 2-bit code on `row_en_o[2r+1:2r]`, where 00 means off (no cell current), 01 selects the true column input and 10 selects the complemented input. Code 11 never appears.
- R2: A row whose captured error is negative (two's complement, row r on `err_i[16r+15:16r]`) uses code 10. A positive error uses code 01.
- R3: A row's select stays on for exactly |error| × scale consecutive cycles, with the scale taken from `scale_i` as an unsigned number.
- R4: No row select turns on during the read interval. With the accepting clock edge counted as edge 0, the pulses begin after edge `READ_CYC`.
- R5: The most negative error code (-32768) is treated as a magnitude of 32767.
- R6: A row with a zero error, or any row when the scale is zero, keeps code 00 for the whole update.
- R7: `done_o` is high for exactly one cycle, after edge `READ_CYC` + the longest row pulse. In that same cycle every row is off.
- R8: A start strobe that arrives between the accepting edge and the done edge (both included) has no effect.
- R9: The error words and the scale are sampled only at the accepting edge. Later changes on those inputs do not alter the running update.
- R10: After reset every row is off and `done_o` is low.
- R11: Rows with different magnitudes run in parallel and end independently, each on its own cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe; accepted only when idle |
| err_i | input | ROWS*ERR_W | Signed error words, row r at bits [ERR_W*r +: ERR_W] |
| scale_i | input | SCALE_W | Unsigned time-scale constant, cycles per unit of error |
| row_en_o | output | 2*ROWS | Per-row select codes (00 off, 01 true, 10 complemented) |
| done_o | output | 1 | One-cycle pulse at the end of an update |

## Verification
Some rules are checked by assertions on every cycle. These are: the illegal code never appears; the select polarity agrees with the captured sign; a lit row has a nonzero count and stays lit while more than one cycle remains; no row is lit outside the write phase; the read interval is held; the done pulse is a single cycle with every row off. Other behaviour can only be shown by the bench scenarios, because it depends on the stimulus as a whole. This covers the exact pulse length for chosen magnitudes and scales, saturation of the most negative code, zero errors and a zero scale, independent end times, and the outcome of a start strobe and new inputs that arrive mid-update.

// File: rtl/rowpw_pkg.sv
package rowpw_pkg;
  typedef enum logic [1:0] {
    EN_OFF = 2'b00,
    EN_POS = 2'b01,
    EN_NEG = 2'b10
  } row_en_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'b00,
    PH_READ  = 2'b01,
    PH_WRITE = 2'b10
  } phase_t;
endpackage

// File: rtl/rowpw_mag.sv
// Absolute value of a two's complement error; the most negative code saturates.
module rowpw_mag #(
  parameter int ERR_W = 16
) (
  input  logic [ERR_W-1:0] err_i,
  output logic [ERR_W-2:0] mag_o,
  output logic             neg_o
);
  localparam logic [ERR_W-1:0] MOST_NEG = {1'b1, {(ERR_W-1){1'b0}}};

  logic [ERR_W-1:0] negated;

  always_comb begin
    negated = ~err_i + {{(ERR_W-1){1'b0}}, 1'b1};
    neg_o   = err_i[ERR_W-1];
    if (err_i == MOST_NEG)
      mag_o = '1;
    else if (err_i[ERR_W-1])
      mag_o = negated[ERR_W-2:0];
    else
      mag_o = err_i[ERR_W-2:0];
  end
endmodule

// File: rtl/rowpw_lane.sv
// One row: captures length and sign at start, counts down in the write phase.
module rowpw_lane
  import rowpw_pkg::*;
#(
  parameter int ERR_W   = 16,
  parameter int SCALE_W = 8,
  parameter int CNT_W   = ERR_W - 1 + SCALE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic               go_i,
  input  logic               dec_i,
  input  logic [ERR_W-1:0]   err_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic [1:0]         en_o,
  output logic               zero_n_o
);
  logic [ERR_W-2:0] mag;
  logic             neg;
  logic [CNT_W-1:0] len;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_n;
  logic             neg_q;
  row_en_t          en_q;

  rowpw_mag #(.ERR_W(ERR_W)) i_mag (
    .err_i (err_i),
    .mag_o (mag),
    .neg_o (neg)
  );

  assign len = CNT_W'(mag) * CNT_W'(scale_i);

  always_comb begin
    if (load_i)
      cnt_n = len;
    else if (dec_i && (cnt_q != '0))
      cnt_n = cnt_q - CNT_W'(1);
    else
      cnt_n = cnt_q;
  end

  assign zero_n_o = (cnt_n == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      neg_q <= 1'b0;
      en_q  <= EN_OFF;
    end else begin
      cnt_q <= cnt_n;
      if (load_i)
        neg_q <= neg;
      if (go_i && (cnt_n != '0))
        en_q <= neg_q ? EN_NEG : EN_POS;
      else
        en_q <= EN_OFF;
    end
  end

  assign en_o = en_q;

  // R1: code 11 is never driven
  p_legal_code_r1: assert property (@(posedge clk) disable iff (rst)
    en_q != 2'b11);

  // R2: a lit row's polarity agrees with the captured sign
  p_polarity_r2: assert property (@(posedge clk) disable iff (rst)
    (en_q != EN_OFF) |-> ((en_q == EN_NEG) == neg_q));

  // R3: a lit row keeps its code while more than one cycle remains
  p_contiguous_r3: assert property (@(posedge clk) disable iff (rst)
    ((en_q != EN_OFF) && (cnt_q > CNT_W'(1))) |=> (en_q == $past(en_q)));

  // R6: a row is lit only while it has count left
  p_lit_needs_count_r6: assert property (@(posedge clk) disable iff (rst)
    (en_q != EN_OFF) |-> (cnt_q != '0));
endmodule

// File: rtl/rowpw_ctrl.sv
// Sequencer: idle, read interval, parallel write phase, done pulse.
module rowpw_ctrl
  import rowpw_pkg::*;
#(
  parameter int READ_CYC = 4
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start_i,
  input  logic   all_zero_i,
  output logic   load_o,
  output logic   go_o,
  output logic   dec_o,
  output logic   done_o,
  output phase_t phase_o
);
  localparam int RD_W = (READ_CYC < 2) ? 1 : $clog2(READ_CYC + 1);

  phase_t          phase_q;
  logic [RD_W-1:0] rd_q;
  logic            done_q;

  assign load_o  = start_i && (phase_q == PH_IDLE);
  assign go_o    = ((phase_q == PH_READ) && (rd_q == '0)) || (phase_q == PH_WRITE);
  assign dec_o   = (phase_q == PH_WRITE);
  assign done_o  = done_q;
  assign phase_o = phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      rd_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            phase_q <= PH_READ;
            rd_q    <= RD_W'(READ_CYC - 1);
          end
        end
        PH_READ: begin
          if (rd_q != '0) begin
            rd_q <= rd_q - RD_W'(1);
          end else if (all_zero_i) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end else begin
            phase_q <= PH_WRITE;
          end
        end
        PH_WRITE: begin
          if (all_zero_i) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // R4: the read interval is not cut short
  p_read_hold_r4: assert property (@(posedge clk) disable iff (rst)
    ((phase_q == PH_READ) && (rd_q != '0)) |=> (phase_q == PH_READ));

  // R7: done lasts one cycle
  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R8: once busy, a start strobe never returns the sequencer to the read interval
  p_busy_start_r8: assert property (@(posedge clk) disable iff (rst)
    ((phase_q == PH_WRITE) && start_i) |=> (phase_q != PH_READ));
endmodule

// File: rtl/rowpw_update_driver.sv
module rowpw_update_driver
  import rowpw_pkg::*;
#(
  parameter int ROWS     = 4,
  parameter int ERR_W    = 16,
  parameter int SCALE_W  = 8,
  parameter int READ_CYC = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic [ROWS*ERR_W-1:0] err_i,
  input  logic [SCALE_W-1:0]    scale_i,
  output logic [2*ROWS-1:0]     row_en_o,
  output logic                  done_o
);
  localparam int CNT_W = ERR_W - 1 + SCALE_W;

  logic            load;
  logic            go;
  logic            dec;
  logic [ROWS-1:0] zero_n;
  phase_t          phase;

  rowpw_ctrl #(.READ_CYC(READ_CYC)) i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .all_zero_i (&zero_n),
    .load_o     (load),
    .go_o       (go),
    .dec_o      (dec),
    .done_o     (done_o),
    .phase_o    (phase)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_lane
    rowpw_lane #(
      .ERR_W   (ERR_W),
      .SCALE_W (SCALE_W),
      .CNT_W   (CNT_W)
    ) i_lane (
      .clk      (clk),
      .rst      (rst),
      .load_i   (load),
      .go_i     (go),
      .dec_i    (dec),
      .err_i    (err_i[ERR_W*r +: ERR_W]),
      .scale_i  (scale_i),
      .en_o     (row_en_o[2*r +: 2]),
      .zero_n_o (zero_n[r])
    );
  end

  // R4: rows are lit only in the write phase
  p_write_phase_r4: assert property (@(posedge clk) disable iff (rst)
    (row_en_o != '0) |-> (phase == PH_WRITE));

  // R7: all rows are released when done is raised
  p_done_rows_off_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (row_en_o == '0));
endmodule

// File: tb/test_rowpw_update_driver.sv
module test_rowpw_update_driver;
  localparam int ROWS = 4;
  localparam int RD   = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [63:0] err_i = '0;
  logic [7:0]  scale_i = '0;
  logic [7:0]  row_en_o;
  logic        done_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #4 clk = ~clk;

  rowpw_update_driver #(.ROWS(ROWS), .ERR_W(16), .SCALE_W(8), .READ_CYC(RD))
    i_rowpw_update_driver (
      .clk(clk), .rst(rst), .start_i(start_i), .err_i(err_i),
      .scale_i(scale_i), .row_en_o(row_en_o), .done_o(done_o));

  function automatic logic [63:0] pack4(int a, int b, int c, int d);
    logic [15:0] a16, b16, c16, d16;
    a16 = 16'(a); b16 = 16'(b); c16 = 16'(c); d16 = 16'(d);
    return {d16, c16, b16, a16};
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // One update; optionally a start strobe with new inputs at sample glitch_k.
  task automatic run_case(input string tag, input logic [63:0] errs, input logic [7:0] sc,
                          input int glitch_k, input logic [63:0] gerrs, input logic [7:0] gsc);
    int len[ROWS];
    int code[ROWS];
    int bad[ROWS];
    int bad_act[ROWS];
    int bad_exp[ROWS];
    int lmax;
    int done_at;
    int done_cnt;
    int quiet_bad;
    lmax = 0;
    for (int r = 0; r < ROWS; r++) begin
      int e;
      int m;
      e = int'($signed(errs[16*r +: 16]));
      m = (e == -32768) ? 32767 : ((e < 0) ? -e : e);   // R5
      len[r] = m * int'(sc);
      code[r] = (len[r] == 0) ? 0 : ((e < 0) ? 2 : 1);  // R1 encoding, R2 sign
      if (len[r] > lmax) lmax = len[r];
      bad[r] = 0; bad_act[r] = 0; bad_exp[r] = 0;
    end
    done_at = -1; done_cnt = 0; quiet_bad = 0;
    @(negedge clk);
    start_i = 1'b1; err_i = errs; scale_i = sc;
    for (int k = 0; k <= RD + lmax + 1; k++) begin
      @(negedge clk);
      for (int r = 0; r < ROWS; r++) begin
        int ex;
        int ac;
        ex = (k >= RD && k < RD + len[r]) ? code[r] : 0;  // R3, R4
        ac = int'(row_en_o[2*r +: 2]);
        if (ac != ex && bad[r] == 0) begin
          bad[r] = k + 1; bad_act[r] = ac; bad_exp[r] = ex;
        end
      end
      if (done_o) begin
        done_cnt++;
        if (done_at < 0) done_at = k;
      end
      if (k == 0) start_i = 1'b0;
      if (k == glitch_k) begin
        start_i = 1'b1; err_i = gerrs; scale_i = gsc;
      end
      if (k == glitch_k + 1) start_i = 1'b0;
    end
    start_i = 1'b0;
    for (int r = 0; r < ROWS; r++)
      check(tag, $sformatf("row %0d code (first bad sample %0d)", r, bad[r] - 1),
            bad_act[r], bad_exp[r]);
    check("R7", "done sample index", done_at, RD + lmax);
    check("R7", "done pulse count", done_cnt, 1);
    for (int k = 0; k < RD + 4; k++) begin
      @(negedge clk);
      if (row_en_o != '0 || done_o) quiet_bad++;
    end
    check("R8", "activity after done", quiet_bad, 0);
  endtask

  task automatic reset_test();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10", "row codes after reset", int'(row_en_o), 0);
    check("R10", "done after reset", int'(done_o), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    reset_test();
    // R11 and R1: mixed signs, independent lengths 10, 6, 14, 2
    run_case("R11", pack4(5, -3, 7, -1), 8'd2, -5, '0, '0);
    // R2: all negative rows, complemented select
    run_case("R2", pack4(-1, -4, -2, -6), 8'd3, -5, '0, '0);
    // R6: zero-error rows stay off
    run_case("R6", pack4(0, 9, 0, -2), 8'd1, -5, '0, '0);
    // R6: zero scale keeps every row off, done right after the read interval
    run_case("R6", pack4(40, -40, 1, -1), 8'd0, -5, '0, '0);
    // R5: most negative code saturates
    run_case("R5", pack4(-32768, 5, -32767, 1), 8'd1, -5, '0, '0);
    // R9 and R8: new inputs and a start strobe mid-update are ignored
    run_case("R9", pack4(3, -3, 4, -4), 8'd5, 6, pack4(100, 100, -100, 7), 8'd7);
    // R8: strobe on the last busy sample before done
    run_case("R8", pack4(2, 0, 0, 0), 8'd3, RD + 5, pack4(9, 9, 9, 9), 8'd9);
    // R4 and R3: single row, full scale
    run_case("R4", pack4(0, 0, 0, 1), 8'd255, -5, '0, '0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule